// File: doc/BRIEF.md
# Serial Configuration Register Bank with Self-Clearing Soft Reset

This block holds the configuration of a clock-distribution core. A 32-bit word is shifted in MSB first on a single data line, one bit per rising edge of `clk`, while the latch-enable line `ser_le` is low. The rising edge of `ser_le` commits the word. The low four bits of the word give the register address. The rest of the word carries field values, which the bank decodes and drives straight to the rest of the design.

Four consecutive addresses, starting at 4, each configure one clock output channel. Each channel has a path mode, an enable, a divide code (the actual divide is twice the code) and a delay code. Address 15 holds the PLL N and R divide values. Address 0 holds the global output enable, power-down, charge-pump tri-state and charge-pump polarity bits. Bit 31 of address 0 is a soft reset. A write to address 0 with that bit set returns every register to its power-on value and discards the other bits of that word. The bit is never stored, so it clears itself.

The capture side is a three-state machine. `ST_SHIFT` shifts a bit in each cycle while `ser_le` is low. Transition *latch* (`ST_SHIFT` to `ST_LOAD`) happens when `ser_le` is seen high. `ST_LOAD` lasts one cycle and issues the commit pulse. Transition *hold* (`ST_LOAD` to `ST_HOLD`) happens while `ser_le` stays high. Transition *quick release* (`ST_LOAD` to `ST_SHIFT`) happens when `ser_le` has already dropped. Transition *release* (`ST_HOLD` to `ST_SHIFT`) happens when `ser_le` falls. The asynchronous active-low `rst_n` puts the machine in `ST_SHIFT` and loads all defaults.

Top module: `cfgbank_top`

## Requirements
- R1: A word is shifted MSB first, one bit per rising `clk` edge while `ser_le` is low. It is committed once per rising edge of `ser_le`, and the new field values appear at the outputs two clock edges after `ser_le` is first sampled high. Word bits [3:0] are the address.
- R2: Addresses 4, 5, 6 and 7 configure channels 0, 1, 2 and 3, using the same layout for each: mode in bits [9:8] (0 bypass, 1 divided, 2 delayed, 3 divided and delayed), enable in bit [10], divide code in bits [23:16], delay code in bits [27:24]. A write to one channel leaves the other channels unchanged.
- R3: After power-on, each channel has mode 0, enable 0, divide code 1 and delay code 0.
- R4: Address 0 sets the global output enable from bit [8], power-down from bit [9], charge-pump tri-state from bit [10] and charge-pump polarity from bit [11] (1 = positive). The defaults are 1, 0, 0 and 0.
- R5: Address 15 sets PLL N from bits [19:4] and PLL R from bits [31:20]. The defaults are 760 and 10.
- R6: A write to address 0 with bit [31] set returns every register of the bank to its default.
- R7: In a write to address 0 that has bit [31] set, every other bit is discarded.
- R8: The soft reset bit is not retained. Writes that follow a soft reset take effect normally.
- R9: Writes to addresses 1, 2, 3, 8 to 14 change no output.
- R10: Asserting `rst_n` low loads every register with its default at any time.
- R11: Outputs change only on a commit. Shifting bits without a latch-enable rising edge, or holding `ser_le` high, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and register clock |
| rst_n | input | 1 | Asynchronous active-low reset to defaults |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; rising edge commits the word |
| ch_mode | output | 8 | Channel path modes, 2 bits per channel, channel 0 in the low bits |
| ch_en | output | 4 | Channel enables |
| ch_div | output | 32 | Channel divide codes, 8 bits per channel |
| ch_dly | output | 16 | Channel delay codes, 4 bits per channel |
| glb_oe | output | 1 | Global output enable |
| pwr_down | output | 1 | Device power-down |
| cp_tristate | output | 1 | Charge-pump tri-state |
| cp_pol_pos | output | 1 | Charge-pump polarity, 1 = positive |
| pll_n | output | 16 | PLL N divide value |
| pll_r | output | 12 | PLL R divide value |

## Verification
Channel words are written with field values that are asymmetric and differ from one channel to the next. A word received LSB first, a channel written at the wrong address, or two swapped fields therefore each produce a visible mismatch. A soft reset word is sent with every other field of address 0 set to non-default values, so that applying those bits is told apart from discarding them. A channel write follows at once, which separates a self-clearing reset bit from one that is stored. Writes to unimplemented addresses, long runs of bits shifted with no latch edge, and `ser_le` held high for many cycles all check that the outputs stay frozen. A mid-run `rst_n` pulse checks the asynchronous defaults.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;
    localparam int MODE_W = 2;
    localparam int DIV_W  = 8;
    localparam int DLY_W  = 4;
    localparam int PLLN_W = 16;
    localparam int PLLR_W = 12;

    // capture state machine
    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_LOAD  = 2'd1,
        ST_HOLD  = 2'd2
    } cap_state_t;

    // channel word layout
    localparam int CH_MODE_LSB = 8;
    localparam int CH_EN_BIT   = 10;
    localparam int CH_DIV_LSB  = 16;
    localparam int CH_DLY_LSB  = 24;

    // global word layout (address 0)
    localparam int GL_OE_BIT   = 8;
    localparam int GL_PD_BIT   = 9;
    localparam int GL_TRI_BIT  = 10;
    localparam int GL_POL_BIT  = 11;
    localparam int GL_SRST_BIT = 31;

    // PLL word layout
    localparam int PLL_N_LSB = 4;
    localparam int PLL_R_LSB = 20;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              en;
        logic [DIV_W-1:0]  div;
        logic [DLY_W-1:0]  dly;
    } chan_cfg_t;

    typedef struct packed {
        logic oe;
        logic pd;
        logic tri_st;
        logic pol;
    } glb_cfg_t;

    localparam chan_cfg_t CHAN_DEF = '{mode: 2'd0, en: 1'b0, div: 8'd1, dly: 4'd0};
    localparam glb_cfg_t  GLB_DEF  = '{oe: 1'b1, pd: 1'b0, tri_st: 1'b0, pol: 1'b0};
    localparam logic [PLLN_W-1:0] PLLN_DEF = 16'd760;
    localparam logic [PLLR_W-1:0] PLLR_DEF = 12'd10;

endpackage

// File: rtl/cfgbank_shifter.sv
module cfgbank_shifter
    import cfgbank_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_data,
    input  logic         ser_le,
    output logic [W-1:0] word,
    output logic         commit
);

    cap_state_t state_q, state_d;
    logic [W-1:0] sreg_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHIFT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHIFT: if (ser_le)  state_d = ST_LOAD;   // latch
            ST_LOAD:  state_d = ser_le ? ST_HOLD        // hold
                                       : ST_SHIFT;      // quick release
            ST_HOLD:  if (!ser_le) state_d = ST_SHIFT;  // release
            default:  state_d = ST_SHIFT;
        endcase
    end

    // outputs
    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            ST_LOAD: commit = 1'b1;
            default: commit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sreg_q <= '0;
        else if (state_q == ST_SHIFT && !ser_le)
            sreg_q <= {sreg_q[W-2:0], ser_data};
    end

    assign word = sreg_q;

endmodule

// File: rtl/cfgbank_chan.sv
module cfgbank_chan
    import cfgbank_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR = 4'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              soft_rst,
    input  logic [WORD_W-1:0] word,
    output chan_cfg_t         cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= CHAN_DEF;
        end else if (soft_rst) begin
            cfg <= CHAN_DEF;
        end else if (commit && word[ADDR_W-1:0] == ADDR) begin
            cfg.mode <= word[CH_MODE_LSB +: MODE_W];
            cfg.en   <= word[CH_EN_BIT];
            cfg.div  <= word[CH_DIV_LSB +: DIV_W];
            cfg.dly  <= word[CH_DLY_LSB +: DLY_W];
        end
    end

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
    import cfgbank_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CH_BASE  = 4,
    parameter int PLL_ADDR = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_data,
    input  logic                    ser_le,
    output logic [NCH*MODE_W-1:0]   ch_mode,
    output logic [NCH-1:0]          ch_en,
    output logic [NCH*DIV_W-1:0]    ch_div,
    output logic [NCH*DLY_W-1:0]    ch_dly,
    output logic                    glb_oe,
    output logic                    pwr_down,
    output logic                    cp_tristate,
    output logic                    cp_pol_pos,
    output logic [PLLN_W-1:0]       pll_n,
    output logic [PLLR_W-1:0]       pll_r
);

    localparam logic [ADDR_W-1:0] GLB_A = '0;
    localparam logic [ADDR_W-1:0] PLL_A = ADDR_W'(PLL_ADDR);

    logic [WORD_W-1:0] word;
    logic              commit;
    logic              soft_rst;
    logic [ADDR_W-1:0] addr;
    glb_cfg_t          glb_q;
    logic [PLLN_W-1:0] n_q;
    logic [PLLR_W-1:0] r_q;

    cfgbank_shifter #(.W(WORD_W)) shifter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_data (ser_data),
        .ser_le   (ser_le),
        .word     (word),
        .commit   (commit)
    );

    assign addr     = word[ADDR_W-1:0];
    assign soft_rst = commit && addr == GLB_A && word[GL_SRST_BIT];

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            chan_cfg_t cfg;
            cfgbank_chan #(.ADDR(ADDR_W'(CH_BASE + g))) chan_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .commit   (commit),
                .soft_rst (soft_rst),
                .word     (word),
                .cfg      (cfg)
            );
            assign ch_mode[g*MODE_W +: MODE_W] = cfg.mode;
            assign ch_en[g]                    = cfg.en;
            assign ch_div[g*DIV_W +: DIV_W]    = cfg.div;
            assign ch_dly[g*DLY_W +: DLY_W]    = cfg.dly;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_q <= GLB_DEF;
        end else if (soft_rst) begin
            glb_q <= GLB_DEF;
        end else if (commit && addr == GLB_A) begin
            glb_q.oe     <= word[GL_OE_BIT];
            glb_q.pd     <= word[GL_PD_BIT];
            glb_q.tri_st <= word[GL_TRI_BIT];
            glb_q.pol    <= word[GL_POL_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= PLLN_DEF;
            r_q <= PLLR_DEF;
        end else if (soft_rst) begin
            n_q <= PLLN_DEF;
            r_q <= PLLR_DEF;
        end else if (commit && addr == PLL_A) begin
            n_q <= word[PLL_N_LSB +: PLLN_W];
            r_q <= word[PLL_R_LSB +: PLLR_W];
        end
    end

    assign glb_oe      = glb_q.oe;
    assign pwr_down    = glb_q.pd;
    assign cp_tristate = glb_q.tri_st;
    assign cp_pol_pos  = glb_q.pol;
    assign pll_n       = n_q;
    assign pll_r       = r_q;

endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
    import cfgbank_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CH_BASE  = 4,
    parameter int PLL_ADDR = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ser_le,
    input logic                  commit,
    input logic [WORD_W-1:0]     word,
    input logic [NCH*MODE_W-1:0] ch_mode,
    input logic [NCH-1:0]        ch_en,
    input logic [NCH*DIV_W-1:0]  ch_div,
    input logic [NCH*DLY_W-1:0]  ch_dly,
    input logic                  glb_oe,
    input logic                  pwr_down,
    input logic                  cp_tristate,
    input logic                  cp_pol_pos,
    input logic [PLLN_W-1:0]     pll_n,
    input logic [PLLR_W-1:0]     pll_r
);

    logic [NCH*(MODE_W+1+DIV_W+DLY_W)+4+PLLN_W+PLLR_W-1:0] all_cfg;
    logic is_srst;
    logic is_impl;
    int   a_int;

    assign all_cfg = {ch_mode, ch_en, ch_div, ch_dly, glb_oe, pwr_down,
                      cp_tristate, cp_pol_pos, pll_n, pll_r};
    assign a_int   = int'(word[ADDR_W-1:0]);
    assign is_srst = (a_int == 0) && word[GL_SRST_BIT];
    assign is_impl = (a_int == 0) || (a_int == PLL_ADDR) ||
                     (a_int >= CH_BASE && a_int < CH_BASE + NCH);

    // R11
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(all_cfg));

    // R1
    commit_after_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(ser_le));

    // R1
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R6
    srst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && is_srst) |=> (pll_n == PLLN_DEF && pll_r == PLLR_DEF &&
                                 ch_en == '0 && glb_oe));

    // R7
    srst_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && is_srst) |=> (!pwr_down && !cp_tristate && !cp_pol_pos));

    // R9
    unimpl_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !is_impl) |=> $stable(all_cfg));

endmodule

bind cfgbank_top cfgbank_chk #(
    .NCH      (NCH),
    .CH_BASE  (CH_BASE),
    .PLL_ADDR (PLL_ADDR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_le      (ser_le),
    .commit      (commit),
    .word        (word),
    .ch_mode     (ch_mode),
    .ch_en       (ch_en),
    .ch_div      (ch_div),
    .ch_dly      (ch_dly),
    .glb_oe      (glb_oe),
    .pwr_down    (pwr_down),
    .cp_tristate (cp_tristate),
    .cp_pol_pos  (cp_pol_pos),
    .pll_n       (pll_n),
    .pll_r       (pll_r)
);

// File: tb/cfgbank_top_tb_top.sv
module cfgbank_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_le = 1'b0;
    logic [7:0]  ch_mode;
    logic [3:0]  ch_en;
    logic [31:0] ch_div;
    logic [15:0] ch_dly;
    logic        glb_oe, pwr_down, cp_tristate, cp_pol_pos;
    logic [15:0] pll_n;
    logic [11:0] pll_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgbank_top dut_i (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_le(ser_le),
        .ch_mode(ch_mode), .ch_en(ch_en), .ch_div(ch_div), .ch_dly(ch_dly),
        .glb_oe(glb_oe), .pwr_down(pwr_down), .cp_tristate(cp_tristate),
        .cp_pol_pos(cp_pol_pos), .pll_n(pll_n), .pll_r(pll_r)
    );

    typedef struct {
        logic [7:0]  mode;
        logic [3:0]  en;
        logic [31:0] dv;
        logic [15:0] dl;
        logic [3:0]  gl;
        logic [15:0] n;
        logic [11:0] r;
        string       tag;
    } snap_t;

    snap_t model;
    snap_t exp_q[$];

    function automatic void model_defaults();
        model.mode = '0;
        model.en   = '0;
        model.dv   = {8'd1, 8'd1, 8'd1, 8'd1};
        model.dl   = '0;
        model.gl   = 4'b1000;  // {oe, pd, tri, pol}
        model.n    = 16'd760;
        model.r    = 12'd10;
    endfunction

    function automatic void model_apply(logic [31:0] w);
        int a;
        a = int'(w[3:0]);
        if (a == 0) begin
            if (w[31]) model_defaults();
            else model.gl = {w[8], w[9], w[10], w[11]};
        end else if (a >= 4 && a <= 7) begin
            model.mode[(a-4)*2 +: 2] = w[9:8];
            model.en[a-4]            = w[10];
            model.dv[(a-4)*8 +: 8]   = w[23:16];
            model.dl[(a-4)*4 +: 4]   = w[27:24];
        end else if (a == 15) begin
            model.n = w[19:4];
            model.r = w[31:20];
        end
    endfunction

    function automatic logic [31:0] chan_word(int a, logic [1:0] m, logic e,
                                              logic [7:0] d, logic [3:0] y);
        logic [31:0] w;
        w = '0;
        w[3:0] = 4'(a);
        w[9:8] = m;
        w[10] = e;
        w[23:16] = d;
        w[27:24] = y;
        return w;
    endfunction

    task automatic push_exp(string tag);
        snap_t s;
        s = model;
        s.tag = tag;
        exp_q.push_back(s);
    endtask

    task automatic shift_bits(logic [31:0] w);
        for (int i = 31; i >= 0; i--) begin
            @(negedge clk);
            ser_data = w[i];
        end
    endtask

    task automatic do_write(logic [31:0] w, string tag);
        @(negedge clk);
        ser_le = 1'b0;
        @(negedge clk);
        shift_bits(w);
        @(negedge clk);
        ser_le = 1'b1;
        repeat (3) @(negedge clk);
        model_apply(w);
        push_exp(tag);
        @(negedge clk);
        ser_le = 1'b0;
    endtask

    task automatic cmp(string tag, string f, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, f, act, exp);
        end
    endtask

    // monitor
    initial begin
        snap_t s;
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                s = exp_q.pop_front();
                cmp(s.tag, "ch_mode", 32'(ch_mode), 32'(s.mode));
                cmp(s.tag, "ch_en", 32'(ch_en), 32'(s.en));
                cmp(s.tag, "ch_div", ch_div, s.dv);
                cmp(s.tag, "ch_dly", 32'(ch_dly), 32'(s.dl));
                cmp(s.tag, "global", 32'({glb_oe, pwr_down, cp_tristate, cp_pol_pos}), 32'(s.gl));
                cmp(s.tag, "pll_n", 32'(pll_n), 32'(s.n));
                cmp(s.tag, "pll_r", 32'(pll_r), 32'(s.r));
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        model_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_exp("R3 power-on defaults, R4 R5 defaults");

        // R1 MSB-first, R2 channel 0
        do_write(chan_word(4, 2'd3, 1'b1, 8'h81, 4'hC), "R1 R2 ch0");
        do_write(chan_word(5, 2'd1, 1'b1, 8'h05, 4'h3), "R2 ch1");
        do_write(chan_word(6, 2'd2, 1'b0, 8'hFF, 4'h9), "R2 ch2");
        do_write(chan_word(7, 2'd0, 1'b1, 8'h40, 4'h1), "R2 ch3");

        // R4 global fields
        w = '0; w[8] = 1'b0; w[9] = 1'b1; w[10] = 1'b0; w[11] = 1'b1;
        do_write(w, "R4 global write");

        // R5 PLL fields
        w = {12'hA35, 16'h1234, 4'hF};
        do_write(w, "R5 pll write");

        // R9 unimplemented addresses
        do_write(32'hFFFF_FFF1, "R9 addr1");
        do_write(32'hFFFF_FFF9, "R9 addr9");
        do_write(32'hFFFF_FFFE, "R9 addr14");

        // R11 shifting without latch edge
        @(negedge clk);
        ser_le = 1'b0;
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            ser_data = i[0] ^ i[2];
        end
        push_exp("R11 shift only");
        // R11 le held high
        do_write(chan_word(4, 2'd1, 1'b0, 8'h22, 4'h2), "R11 pre-hold");
        @(negedge clk);
        ser_le = 1'b1;
        repeat (20) @(negedge clk);
        push_exp("R11 le held high");
        @(negedge clk);
        ser_le = 1'b0;

        // R6 R7 soft reset with other fields non-default
        w = '0; w[31] = 1'b1; w[8] = 1'b0; w[9] = 1'b1; w[10] = 1'b1; w[11] = 1'b1;
        w[30:12] = 19'h7ABCD;
        do_write(w, "R6 R7 soft reset");

        // R8 following writes take effect
        do_write(chan_word(6, 2'd2, 1'b1, 8'h10, 4'h7), "R8 write after soft reset");
        w = '0; w[9] = 1'b1;
        do_write(w, "R8 global after soft reset");

        // R10 global reset mid-run
        do_write({12'h003, 16'h0100, 4'hF}, "R10 pre-reset");
        @(negedge clk);
        rst_n = 1'b0;
        model_defaults();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_exp("R10 async reset defaults");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule